// File: doc/BRIEF.md
# Branch and Jump Target Unit

This block sits in the execute stage of a 32-bit processor that has one delay slot after every control-flow instruction. Each cycle it can take one decoded control-flow operation together with its instruction address and register operands. It decides whether the operation transfers control and computes the next fetch address after the delay slot. It also works out whether a return address has to be written and where. It flags a register-indirect target whose low bits are not zero, and it tells the pipeline when a likely-form branch must squash its delay-slot instruction.

All results come out of one register stage, one clock after the operation is presented. Instruction fetch, the register file and exception vectoring sit outside the block. The pipeline uses the misaligned flag to raise an address exception once the delay-slot instruction has retired.

Top module: `branch_jump_unit`

## Requirements
- R1: A synchronous active-high reset clears `out_valid`, `out_taken`, `out_link_we`, `out_annul`, `out_misalign`, `out_target` and `out_link_val`. Results appear exactly one clock after `in_valid` is sampled high. A cycle with `in_valid` low gives `out_valid` low and all flags, the target and the link value zero.
- R2: `in_kind` selects the operation. 0 is rs==rt, 1 is rs!=rt, 2 is rs<0, 3 is rs<=0, 4 is rs>0 and 5 is rs>=0, all compared as signed 32-bit integers. 6 is an absolute region jump and 7 is a register-indirect jump. Kinds 0 to 5 set `out_taken` when their condition holds, and kinds 6 and 7 always set it.
- R3: A taken branch has the target (instruction address + 8) + sign-extended (offset << 2), with the 18-bit shifted offset sign-extended to 32 bits. A branch that is not taken has the target instruction address + 8.
- R4: An absolute jump has the target {bits 31:28 of (instruction address + 4), index, 2'b00}.
- R5: A register-indirect jump has the target rs, unchanged. `out_misalign` is set when rs[1:0] is not zero, and it is never set for any other kind.
- R6: When `in_link` is set on kinds 0 to 6, `out_link_we` is set whether or not the branch is taken. In that case `out_link_idx` is 31 and `out_link_val` is the instruction address + 8.
- R7: When `in_link` is set on kind 7, the link index is `in_link_dst` and the value is the instruction address + 8. A destination of 0 suppresses `out_link_we`, because writes to register 0 are discarded.
- R8: `out_annul` is set only for kinds 0 to 5 with `in_likely` set and the condition false. `in_likely` has no effect on kinds 6 and 7.
- R9: `in_pc[1:0]` is ignored and treated as zero. Every target that is not a misaligned register target, and every link value, has its two low bits at zero.
- R10: Kinds 8 to 15 are not taken and give no link, no annul and no misalign. Their target is the instruction address + 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| in_kind | input | 4 | Operation kind (see R2, R10) |
| in_link | input | 1 | Operation writes a return address |
| in_likely | input | 1 | Likely form: annul delay slot when not taken |
| in_pc | input | 32 | Address of the control-flow instruction |
| in_rs | input | 32 | First register operand |
| in_rt | input | 32 | Second register operand |
| in_offset | input | 16 | Branch word offset |
| in_index | input | 26 | Absolute jump word index |
| in_link_dst | input | 5 | Link destination for register-indirect jumps |
| out_valid | output | 1 | Results valid |
| out_taken | output | 1 | Control transfers to target |
| out_target | output | 32 | Fetch address after the delay slot |
| out_link_we | output | 1 | Return address write enable |
| out_link_idx | output | 5 | Return address register index |
| out_link_val | output | 32 | Return address value |
| out_annul | output | 1 | Squash the delay-slot instruction |
| out_misalign | output | 1 | Register target misaligned; raise exception after delay slot |

## Verification
Every result (taken, target, link write, annul and misalign) is due one clock after the operation is sampled, because all of them pass through the same single output register. The bench drives each operation on a falling edge and computes its expected results at that point. At the next falling edge it compares them with the outputs, so each comparison lands half a period after the rising edge that loaded the register. The reset check and the check with `in_valid` low follow the same one-cycle rule.

// File: rtl/bju_pkg.sv
package bju_pkg;
  typedef logic [3:0] kind_t;

  localparam kind_t KIND_EQ   = 4'd0;
  localparam kind_t KIND_NE   = 4'd1;
  localparam kind_t KIND_LTZ  = 4'd2;
  localparam kind_t KIND_LEZ  = 4'd3;
  localparam kind_t KIND_GTZ  = 4'd4;
  localparam kind_t KIND_GEZ  = 4'd5;
  localparam kind_t KIND_JABS = 4'd6;
  localparam kind_t KIND_JREG = 4'd7;

  function automatic logic kind_is_branch(input kind_t k);
    return k <= KIND_GEZ;
  endfunction

  function automatic logic kind_is_flow(input kind_t k);
    return k <= KIND_JREG;
  endfunction
endpackage

// File: rtl/bju_cond.sv
module bju_cond
  import bju_pkg::*;
#(
  parameter int W = 32
) (
  input  kind_t        kind,
  input  logic [W-1:0] rs,
  input  logic [W-1:0] rt,
  output logic         cond_true
);
  logic rs_neg, rs_zero, ops_equal;

  always_comb begin
    rs_neg    = $signed(rs) < 0;
    rs_zero   = (rs == '0);
    ops_equal = (rs == rt);
    unique case (kind)
      KIND_EQ:  cond_true = ops_equal;
      KIND_NE:  cond_true = !ops_equal;
      KIND_LTZ: cond_true = rs_neg;
      KIND_LEZ: cond_true = rs_neg || rs_zero;
      KIND_GTZ: cond_true = !rs_neg && !rs_zero;
      KIND_GEZ: cond_true = !rs_neg;
      default:  cond_true = 1'b0;
    endcase
  end
endmodule

// File: rtl/bju_target.sv
module bju_target
  import bju_pkg::*;
#(
  parameter int W     = 32,
  parameter int IMM_W = 16,
  parameter int IDX_W = 26
) (
  input  kind_t            kind,
  input  logic [W-1:0]     pc,
  input  logic [W-1:0]     rs,
  input  logic [IMM_W-1:0] offset,
  input  logic [IDX_W-1:0] index,
  input  logic             cond_true,
  output logic             taken,
  output logic [W-1:0]     target,
  output logic             misalign
);
  localparam int OFF_W    = IMM_W + 2;
  localparam int REGION_W = W - IDX_W - 2;

  logic [W-1:0] slot_pc, after_slot, br_disp, br_dest, region_dest;

  always_comb begin
    slot_pc     = pc + W'(4);
    after_slot  = pc + W'(8);
    br_disp     = {{(W-OFF_W){offset[IMM_W-1]}}, offset, 2'b00};
    br_dest     = after_slot + br_disp;
    region_dest = {slot_pc[W-1 -: REGION_W], index, 2'b00};
    taken       = 1'b0;
    misalign    = 1'b0;
    target      = slot_pc;
    if (kind_is_branch(kind)) begin
      taken  = cond_true;
      target = cond_true ? br_dest : after_slot;
    end else if (kind == KIND_JABS) begin
      taken  = 1'b1;
      target = region_dest;
    end else if (kind == KIND_JREG) begin
      taken    = 1'b1;
      target   = rs;
      misalign = (rs[1:0] != 2'b00);
    end
  end
endmodule

// File: rtl/bju_link.sv
module bju_link
  import bju_pkg::*;
#(
  parameter int W        = 32,
  parameter int RIDX_W   = 5,
  parameter int LINK_REG = 31
) (
  input  kind_t             kind,
  input  logic              link_req,
  input  logic [RIDX_W-1:0] dst,
  input  logic [W-1:0]      pc,
  output logic              we,
  output logic [RIDX_W-1:0] idx,
  output logic [W-1:0]      val
);
  always_comb begin
    idx = (kind == KIND_JREG) ? dst : RIDX_W'(LINK_REG);
    we  = link_req && kind_is_flow(kind) && (idx != '0);
    val = pc + W'(8);
  end
endmodule

// File: rtl/branch_jump_unit.sv
module branch_jump_unit
  import bju_pkg::*;
#(
  parameter int W        = 32,
  parameter int IMM_W    = 16,
  parameter int IDX_W    = 26,
  parameter int RIDX_W   = 5,
  parameter int LINK_REG = 31
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [3:0]        in_kind,
  input  logic              in_link,
  input  logic              in_likely,
  input  logic [W-1:0]      in_pc,
  input  logic [W-1:0]      in_rs,
  input  logic [W-1:0]      in_rt,
  input  logic [IMM_W-1:0]  in_offset,
  input  logic [IDX_W-1:0]  in_index,
  input  logic [RIDX_W-1:0] in_link_dst,
  output logic              out_valid,
  output logic              out_taken,
  output logic [W-1:0]      out_target,
  output logic              out_link_we,
  output logic [RIDX_W-1:0] out_link_idx,
  output logic [W-1:0]      out_link_val,
  output logic              out_annul,
  output logic              out_misalign
);
  kind_t             kind;
  logic [W-1:0]      pc_al;
  logic              cond_true, nx_taken, nx_misalign, nx_we, nx_annul;
  logic [W-1:0]      nx_target, nx_link_val;
  logic [RIDX_W-1:0] nx_idx;

  assign kind  = in_kind;
  assign pc_al = {in_pc[W-1:2], 2'b00};

  bju_cond #(.W(W)) u_cond (
    .kind(kind), .rs(in_rs), .rt(in_rt), .cond_true(cond_true)
  );

  bju_target #(.W(W), .IMM_W(IMM_W), .IDX_W(IDX_W)) u_target (
    .kind(kind), .pc(pc_al), .rs(in_rs), .offset(in_offset), .index(in_index),
    .cond_true(cond_true), .taken(nx_taken), .target(nx_target),
    .misalign(nx_misalign)
  );

  bju_link #(.W(W), .RIDX_W(RIDX_W), .LINK_REG(LINK_REG)) u_link (
    .kind(kind), .link_req(in_link), .dst(in_link_dst), .pc(pc_al),
    .we(nx_we), .idx(nx_idx), .val(nx_link_val)
  );

  assign nx_annul = in_likely && kind_is_branch(kind) && !cond_true;

  always_ff @(posedge clk) begin
    if (rst || !in_valid) begin
      out_valid    <= 1'b0;
      out_taken    <= 1'b0;
      out_target   <= '0;
      out_link_we  <= 1'b0;
      out_link_idx <= '0;
      out_link_val <= '0;
      out_annul    <= 1'b0;
      out_misalign <= 1'b0;
    end else begin
      out_valid    <= 1'b1;
      out_taken    <= nx_taken;
      out_target   <= nx_target;
      out_link_we  <= nx_we;
      out_link_idx <= nx_idx;
      out_link_val <= nx_we ? nx_link_val : '0;
      out_annul    <= nx_annul;
      out_misalign <= nx_misalign;
    end
  end

  assert_latency_R1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> !(out_taken || out_link_we || out_annul || out_misalign));
  assert_annul_not_taken_R8: assert property (@(posedge clk) disable iff (rst)
    out_annul |-> !out_taken);
  assert_misalign_taken_R5: assert property (@(posedge clk) disable iff (rst)
    out_misalign |-> out_taken);
  assert_no_zero_link_R7: assert property (@(posedge clk) disable iff (rst)
    out_link_we |-> out_link_idx != '0);
  assert_aligned_target_R9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_misalign) |-> out_target[1:0] == 2'b00);
  assert_link_aligned_R6: assert property (@(posedge clk) disable iff (rst)
    out_link_we |-> out_link_val[1:0] == 2'b00);
endmodule

// File: tb/branch_jump_unit_bench.sv
module branch_jump_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst = 1'b1;
  logic        in_valid = 0, in_link = 0, in_likely = 0;
  logic [3:0]  in_kind = 0;
  logic [31:0] in_pc = 0, in_rs = 0, in_rt = 0;
  logic [15:0] in_offset = 0;
  logic [25:0] in_index = 0;
  logic [4:0]  in_link_dst = 0;
  logic        out_valid, out_taken, out_link_we, out_annul, out_misalign;
  logic [31:0] out_target, out_link_val;
  logic [4:0]  out_link_idx;

  int checks = 0, errors = 0;
  logic done = 0;

  logic        e_valid, e_taken, e_we, e_annul, e_mis;
  logic [31:0] e_target, e_lval;
  logic [4:0]  e_lidx;

  always #(CLK_PERIOD/2) clk = ~clk;

  branch_jump_unit u_branch_jump_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_kind(in_kind),
    .in_link(in_link), .in_likely(in_likely), .in_pc(in_pc), .in_rs(in_rs),
    .in_rt(in_rt), .in_offset(in_offset), .in_index(in_index),
    .in_link_dst(in_link_dst), .out_valid(out_valid), .out_taken(out_taken),
    .out_target(out_target), .out_link_we(out_link_we),
    .out_link_idx(out_link_idx), .out_link_val(out_link_val),
    .out_annul(out_annul), .out_misalign(out_misalign)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Behavioural model of the requirements.
  task automatic model();
    logic [31:0] base;
    int a, b;
    bit cond;
    base = in_pc & 32'hFFFF_FFFC;          // R9
    a = int'(in_rs); b = int'(in_rt);
    e_valid = in_valid; e_taken = 0; e_we = 0; e_annul = 0; e_mis = 0;
    e_target = base + 4; e_lval = 0; e_lidx = 31;
    case (in_kind)
      0: cond = (a == b);
      1: cond = (a != b);
      2: cond = (a < 0);
      3: cond = (a <= 0);
      4: cond = (a > 0);
      5: cond = (a >= 0);
      default: cond = 1;
    endcase
    if (in_kind <= 5) begin
      e_taken  = cond;
      e_target = cond ? base + 8 + 32'(int'($signed(in_offset)) * 4) : base + 8;
      e_annul  = in_likely && !cond;
    end else if (in_kind == 6) begin
      e_taken = 1;
      e_target = ((base + 4) & 32'hF000_0000) | (32'(in_index) << 2);
    end else if (in_kind == 7) begin
      e_taken = 1; e_target = in_rs; e_mis = (in_rs[1:0] != 0);
      e_lidx = in_link_dst;
    end
    if (in_kind <= 7 && in_link && e_lidx != 0) begin
      e_we = 1; e_lval = base + 8;
    end
    if (!in_valid) begin
      e_taken = 0; e_target = 0; e_we = 0; e_annul = 0; e_mis = 0; e_lval = 0;
    end
  endtask

  function automatic string ttag(input logic [3:0] k);
    if (k <= 5) return "R3";
    if (k == 6) return "R4";
    if (k == 7) return "R5";
    return "R10";
  endfunction

  task automatic step(input bit v, input logic [3:0] k, input bit lk, input bit lkly,
                      input logic [31:0] pc, input logic [31:0] rs, input logic [31:0] rt,
                      input logic [15:0] off, input logic [25:0] idx, input logic [4:0] dst);
    in_valid = v; in_kind = k; in_link = lk; in_likely = lkly; in_pc = pc;
    in_rs = rs; in_rt = rt; in_offset = off; in_index = idx; in_link_dst = dst;
    model();
    @(negedge clk);
    chk(out_valid == e_valid, "R1", "valid", 32'(out_valid), 32'(e_valid));
    chk(out_taken == e_taken, (k > 7) ? "R10" : "R2", "taken", 32'(out_taken), 32'(e_taken));
    chk(out_target == e_target, v ? ttag(k) : "R1", "target", out_target, e_target);
    chk(out_link_we == e_we, (k == 7) ? "R7" : "R6", "link_we", 32'(out_link_we), 32'(e_we));
    if (e_we) begin
      chk(out_link_idx == e_lidx, (k == 7) ? "R7" : "R6", "link_idx", 32'(out_link_idx), 32'(e_lidx));
      chk(out_link_val == e_lval, "R6", "link_val", out_link_val, e_lval);
    end
    chk(out_annul == e_annul, "R8", "annul", 32'(out_annul), 32'(e_annul));
    chk(out_misalign == e_mis, "R5", "misalign", 32'(out_misalign), 32'(e_mis));
  endtask

  initial begin
    for (int c = 0; c < 200000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(out_valid == 0 && out_taken == 0 && out_link_we == 0 && out_annul == 0
        && out_misalign == 0 && out_target == 0, "R1", "reset", out_target, 0);
    rst = 0;
    // R2/R3: signed conditions, forward and backward offsets
    step(1, 0, 0, 0, 32'h0000_1000, 32'd5, 32'd5, 16'h0004, 0, 0);
    step(1, 1, 0, 0, 32'h0000_1000, 32'd5, 32'd5, 16'hFFFF, 0, 0);
    step(1, 2, 0, 0, 32'h0000_2000, 32'h8000_0000, 0, 16'h8000, 0, 0);
    step(1, 3, 0, 0, 32'h0000_2000, 32'd0, 0, 16'h7FFF, 0, 0);
    step(1, 4, 0, 0, 32'h0000_2000, 32'h7FFF_FFFF, 0, 16'hFFFE, 0, 0);
    step(1, 4, 0, 0, 32'h0000_2000, 32'hFFFF_FFFF, 0, 16'h0010, 0, 0);
    step(1, 5, 0, 0, 32'h0000_2000, 32'hFFFF_FFFF, 0, 16'h0010, 0, 0);
    // R4: region jump, delay slot crossing a region boundary
    step(1, 6, 0, 0, 32'h1FFF_FFFC, 0, 0, 0, 26'h3FF_FFFF, 0);
    step(1, 6, 1, 1, 32'hA000_0040, 0, 0, 0, 26'h000_0123, 0); // R6, R8 ignored
    // R5: register jump aligned and misaligned
    step(1, 7, 0, 0, 32'h0000_3000, 32'hBFC0_0000, 0, 0, 0, 0);
    step(1, 7, 0, 1, 32'h0000_3000, 32'hBFC0_0002, 0, 0, 0, 0);
    // R7: selectable destination, and register 0 suppressed
    step(1, 7, 1, 0, 32'h0000_3000, 32'h0000_4000, 0, 0, 0, 5'd9);
    step(1, 7, 1, 0, 32'h0000_3000, 32'h0000_4000, 0, 0, 0, 5'd0);
    // R6: linking branch not taken still links
    step(1, 2, 1, 0, 32'h0000_5000, 32'd1, 0, 16'h0008, 0, 0);
    // R8: likely branch not taken and taken
    step(1, 0, 0, 1, 32'h0000_6000, 32'd1, 32'd2, 16'h0008, 0, 0);
    step(1, 0, 0, 1, 32'h0000_6000, 32'd3, 32'd3, 16'h0008, 0, 0);
    // R9: low pc bits ignored
    step(1, 0, 1, 0, 32'h0000_7003, 32'd3, 32'd3, 16'h0001, 0, 0);
    // R10: unused kinds
    step(1, 9, 1, 1, 32'h0000_8000, 0, 0, 16'h0004, 26'h1, 5'd3);
    step(1, 15, 1, 0, 32'h0000_8000, 0, 0, 0, 0, 0);
    // R1: invalid cycle
    step(0, 0, 1, 1, 32'h0000_9000, 0, 0, 16'h0004, 0, 0);
    for (int i = 0; i < 600; i++) begin
      logic [31:0] r1, r2;
      r1 = $urandom;
      r2 = ($urandom % 3 == 0) ? r1 : $urandom;
      if ($urandom % 5 == 0) r1 = 0;
      step(($urandom % 8) != 0, 4'($urandom), 1'($urandom), 1'($urandom), $urandom,
           r1, r2, 16'($urandom), 26'($urandom), 5'($urandom));
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule